// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers single-cycle event pulses from the units around it into a 32-bit status word. Each status bit is sticky: once an event or a software request raises it, it stays high until software writes a 1 to it at the status offset. A set offset lets software raise any bit on demand, which is useful for testing interrupt handlers and for software-generated interrupts.

A 32-bit mask word decides which status bits may reach the host. The mask has inverted polarity: a bit at 0 enables its source, and a bit at 1 suppresses it. The single interrupt line is a registered OR of every status bit whose mask bit is 0. After reset every source is disabled and the status word is clear. Only ten bit positions have hardware sources. Pulses on the other event inputs are discarded, so those bits change only through the set offset.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status register reads 0x00000000, the mask register reads 0xFFFFFFFF and irq_o is 0.
- R2: An event pulse on a bit with a hardware source sets that status bit at the next clock edge. The bit then stays set until it is cleared by software.
- R3: Event pulses on bits without a hardware source have no effect on the status register.
- R4: Writing a word to offset 0x44 sets every status bit where the word has a 1 and leaves the other bits unchanged. This works for every one of the 32 bits. A read of offset 0x44 returns 0.
- R5: Writing a word to offset 0x40 clears every status bit where the word has a 1. Bits where the word has a 0 are unchanged. A read of 0x40 returns the status word.
- R6: When a hardware event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R7: A write to offset 0x48 loads the mask, and reading 0x48 returns it. irq_o equals, one cycle later, the OR of (status AND NOT mask).
- R8: A status bit whose mask bit is 1 does not drive irq_o. Clearing that mask bit while the status bit is set raises irq_o one cycle after the mask write. Setting the mask bit again lowers irq_o one cycle later.
- R9: A read of any offset other than 0x40, 0x44 or 0x48 returns 0. A write to any other offset changes neither the status nor the mask.
- R10: The hardware-sourced bits are exactly bits 31, 30, 29, 28, 27, 24, 22, 20, 19 and 18. Together they form the source vector 0xF95C0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_i | input | 32 | One-cycle event pulses, one per status bit |
| irq_o | output | 1 | Level-sensitive interrupt line to the host, registered |

## Verification
The hardest case to reach from the ports is a hardware event landing on a bit in the very cycle that software clears it. Random traffic seldom lines these two up on one bit. A directed step therefore pulses bit 20 and writes 1 to bit 20 at the status offset together, then reads the status back. Random cycles then mix dense event vectors with clears, sets and mask writes of random data at all three offsets. This drives many partial collisions and mask changes while status bits are pending.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int IRQ_W = 32;
  typedef logic [IRQ_W-1:0] irq_vec_t;

  // positions of bits that have a hardware source
  localparam int POS_ENC_START = 31;
  localparam int POS_ENC_EOS   = 30;
  localparam int POS_ENC_VBI   = 29;
  localparam int POS_VIN_RESET = 28;
  localparam int POS_ENC_DMA   = 27;
  localparam int POS_AUD_MODE  = 24;
  localparam int POS_DEC_REQ   = 22;
  localparam int POS_DEC_DMA   = 20;
  localparam int POS_VBI_INS   = 19;
  localparam int POS_DEC_LLERR = 18;

  function automatic irq_vec_t src_map();
    irq_vec_t v;
    v = '0;
    v[POS_ENC_START] = 1'b1;
    v[POS_ENC_EOS]   = 1'b1;
    v[POS_ENC_VBI]   = 1'b1;
    v[POS_VIN_RESET] = 1'b1;
    v[POS_ENC_DMA]   = 1'b1;
    v[POS_AUD_MODE]  = 1'b1;
    v[POS_DEC_REQ]   = 1'b1;
    v[POS_DEC_DMA]   = 1'b1;
    v[POS_VBI_INS]   = 1'b1;
    v[POS_DEC_LLERR] = 1'b1;
    return v;
  endfunction

  // the enabled part of the status word (mask bit 0 enables)
  function automatic irq_vec_t enabled_bits(irq_vec_t st, irq_vec_t msk);
    return st & ~msk;
  endfunction

  function automatic logic any_bit(irq_vec_t v);
    return |v;
  endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] SET_OFS  = 8'h44,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h48
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr,
  input  irq_pkg::irq_vec_t     wdata,
  input  irq_pkg::irq_vec_t     status_q,
  input  irq_pkg::irq_vec_t     mask_q,
  output irq_pkg::irq_vec_t     set_vec,
  output irq_pkg::irq_vec_t     clr_vec,
  output logic                  mask_we,
  output irq_pkg::irq_vec_t     rdata
);

  logic hit_stat;
  logic hit_set;
  logic hit_mask;

  assign hit_stat = (addr == STAT_OFS);
  assign hit_set  = (addr == SET_OFS);
  assign hit_mask = (addr == MASK_OFS);

  assign set_vec = (wr && hit_set)  ? wdata : '0;
  assign clr_vec = (wr && hit_stat) ? wdata : '0;
  assign mask_we = wr && hit_mask;

  always_comb begin
    if (hit_stat)      rdata = status_q;
    else if (hit_mask) rdata = mask_q;
    else               rdata = '0;
  end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank (
  input  logic               clk,
  input  logic               rst_n,
  input  irq_pkg::irq_vec_t  hw_vec,
  input  irq_pkg::irq_vec_t  set_vec,
  input  irq_pkg::irq_vec_t  clr_vec,
  output irq_pkg::irq_vec_t  st_q
);
  import irq_pkg::*;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                      st_q[i] <= 1'b0;
      else if (hw_vec[i] || set_vec[i]) st_q[i] <= 1'b1;
      else if (clr_vec[i])             st_q[i] <= 1'b0;
    end
  end

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((st_q & $past(st_q & ~clr_vec)) == $past(st_q & ~clr_vec)));

  // R6
  hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((st_q & $past(hw_vec)) == $past(hw_vec)));

  // R5
  clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((st_q & $past(clr_vec & ~hw_vec & ~set_vec)) == '0));

  // R4
  set_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((st_q & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  irq_pkg::irq_vec_t  wdata,
  input  irq_pkg::irq_vec_t  status_q,
  output irq_pkg::irq_vec_t  mask_q,
  output logic               pend_any
);
  import irq_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)  mask_q <= '1;
    else if (we) mask_q <= wdata;
  end

  assign pend_any = any_bit(enabled_bits(status_q, mask_q));

  // R1
  mask_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&mask_q));

  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && we) |=> (mask_q == $past(wdata)));

endmodule

// File: rtl/irq_line_reg.sv
module irq_line_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_any,
  output logic irq_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend_any;
  end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] SET_OFS  = 8'h44,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h48,
  parameter logic [31:0] SRC_BITS = irq_pkg::src_map()
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       evt_i,
  output logic              irq_o
);
  import irq_pkg::*;

  irq_vec_t hw_vec;
  irq_vec_t set_vec;
  irq_vec_t clr_vec;
  irq_vec_t status_q;
  irq_vec_t mask_q;
  logic     mask_we;
  logic     pend_any;

  // only sourced positions accept hardware events
  assign hw_vec = evt_i & SRC_BITS;

  irq_bus_decode #(
    .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .SET_OFS(SET_OFS), .MASK_OFS(MASK_OFS)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .status_q(status_q), .mask_q(mask_q),
    .set_vec(set_vec), .clr_vec(clr_vec), .mask_we(mask_we), .rdata(bus_rdata)
  );

  irq_status_bank u_bank (
    .clk(clk), .rst_n(rst_n), .hw_vec(hw_vec), .set_vec(set_vec),
    .clr_vec(clr_vec), .st_q(status_q)
  );

  irq_mask_reg u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(bus_wdata),
    .status_q(status_q), .mask_q(mask_q), .pend_any(pend_any)
  );

  irq_line_reg u_line (
    .clk(clk), .rst_n(rst_n), .pend_any(pend_any), .irq_q(irq_o)
  );

  // R3
  unsourced_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((status_q & ~$past(status_q)) & ~SRC_BITS & ~$past(set_vec)) == '0));

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_o == ($past(status_q & ~mask_q) != '0)));

  // R8
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && (&mask_q)) |=> !irq_o);

endmodule

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] evt_i = '0;
  logic        irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] m_stat = '0;
  logic [31:0] m_mask = '1;
  logic        m_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i), .irq_o(irq_o)
  );

  // R10: sourced positions listed one by one
  function automatic logic [31:0] sourced();
    int pos [10] = '{18, 19, 20, 22, 24, 27, 28, 29, 30, 31};
    logic [31:0] v = '0;
    foreach (pos[k]) v[pos[k]] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] next_stat(logic [31:0] st, logic [31:0] ev,
                                            logic wr, logic [7:0] a, logic [31:0] wd);
    logic [31:0] r = st;
    logic [31:0] src = sourced();
    for (int b = 0; b < 32; b++) begin
      if (wr && a == 8'h40 && wd[b]) r[b] = 1'b0;
      if (wr && a == 8'h44 && wd[b]) r[b] = 1'b1;
      if (ev[b] && src[b])           r[b] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [31:0] read_exp(logic [7:0] a);
    if (a == 8'h40) return m_stat;
    if (a == 8'h48) return m_mask;
    return 32'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // one clock: drive, update model at edge, check irq at the next falling edge
  task automatic step(string req, logic [7:0] a, logic wr, logic [31:0] wd, logic [31:0] ev);
    bus_addr = a; bus_wr = wr; bus_wdata = wd; evt_i = ev;
    @(posedge clk);
    m_irq  = ((m_stat & ~m_mask) != 0);
    m_stat = next_stat(m_stat, ev, wr, a, wd);
    if (wr && a == 8'h48) m_mask = wd;
    @(negedge clk);
    bus_wr = 1'b0; evt_i = '0;
    chk(req, {31'b0, irq_o}, {31'b0, m_irq});
  endtask

  task automatic rd(string req, logic [7:0] a);
    bus_addr = a; bus_wr = 1'b0; evt_i = '0;
    #1;
    chk(req, bus_rdata, read_exp(a));
  endtask

  function automatic string tag_of(logic [7:0] a);
    if (a == 8'h40) return "R2";
    if (a == 8'h44) return "R4";
    if (a == 8'h48) return "R7";
    return "R9";
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] addrs [5] = '{8'h40, 8'h44, 8'h48, 8'h10, 8'h4C};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1", 8'h40);
    rd("R1", 8'h48);
    chk("R1", {31'b0, irq_o}, 32'h0);
    // R2 event on a sourced bit, masked so no irq (R8)
    step("R8", 8'h00, 1'b0, 32'h0, 32'h0800_0000);
    rd("R2", 8'h40);
    step("R2", 8'h00, 1'b0, 32'h0, 32'h0);
    step("R2", 8'h00, 1'b0, 32'h0, 32'h0);
    rd("R2", 8'h40);
    // R3 unsourced events dropped
    step("R3", 8'h00, 1'b0, 32'h0, ~sourced());
    rd("R3", 8'h40);
    // R4 software set of an unsourced bit, set offset reads zero
    step("R4", 8'h44, 1'b1, 32'h0000_0001, 32'h0);
    rd("R4", 8'h40);
    rd("R4", 8'h44);
    // R5 write-one-to-clear bit 27 only
    step("R5", 8'h40, 1'b1, 32'h0800_0000, 32'h0);
    rd("R5", 8'h40);
    // R6 event and clear on bit 20 in one cycle
    step("R6", 8'h40, 1'b1, 32'h0010_0000, 32'h0010_0000);
    rd("R6", 8'h40);
    // R7 unmask bit 20: irq one cycle after the mask write
    step("R7", 8'h48, 1'b1, 32'hFFEF_FFFF, 32'h0);
    rd("R7", 8'h48);
    step("R7", 8'h00, 1'b0, 32'h0, 32'h0);
    chk("R7", {31'b0, irq_o}, 32'h1);
    // R8 mask it again: irq drops one cycle later
    step("R8", 8'h48, 1'b1, 32'hFFFF_FFFF, 32'h0);
    step("R8", 8'h00, 1'b0, 32'h0, 32'h0);
    chk("R8", {31'b0, irq_o}, 32'h0);
    // R9 unmapped offset
    step("R9", 8'h10, 1'b1, 32'hFFFF_FFFF, 32'h0);
    rd("R9", 8'h10);
    rd("R9", 8'h40);
    rd("R9", 8'h48);
    // R10 every source at once, after clearing all
    step("R10", 8'h40, 1'b1, 32'hFFFF_FFFF, 32'h0);
    step("R10", 8'h00, 1'b0, 32'h0, 32'hFFFF_FFFF);
    rd("R10", 8'h40);
    chk("R10", bus_rdata, 32'hF95C_0000);
    // random phase
    for (int n = 0; n < 600; n++) begin
      logic [7:0]  a = addrs[$urandom_range(0, 4)];
      logic        w = ($urandom_range(0, 2) == 0);
      logic [31:0] wd = $urandom & $urandom;
      logic [31:0] ev = $urandom & $urandom & $urandom;
      if (a == 8'h48 && ($urandom_range(0, 1) == 1)) wd = ~wd;
      step("R7", a, w, wd, ev);
      begin
        logic [7:0] ra = addrs[$urandom_range(0, 4)];
        rd(tag_of(ra), ra);
      end
    end
    finish_run();
  end

endmodule